// File: doc/BRIEF.md
# Descriptor Ring Register Decoder

This block sits behind the register port of a switch controller. It owns the control registers of a bank of DMA descriptor rings: one command ring, one event ring, and a transmit ring and a receive ring for every front-panel port. Ring 0 carries commands and ring 1 carries events. From ring 2 upward, each port takes one even-numbered transmit ring followed by one odd-numbered receive ring. Each register access is checked against the ring window. The address is then split into a ring index and a register offset. The block keeps, per ring, a 64-bit base address, a size, a head, a tail, an enable and a credit count.

The descriptor engine does not access these registers. It reports each posted descriptor with a one-cycle pulse naming the ring. That pulse moves the ring's tail forward and adds one credit. A head write that hands over new work, or a credit return that leaves credits outstanding, raises an interrupt request one cycle later. The request carries the ring's vector, its 1-based front-panel port and a receive flag. Reads are combinational on a separate read address.

Top module: `ring_reg_decoder`

## Requirements
- R1: An address hits the ring window only when WIN_BASE <= addr < WIN_BASE + 32*(2+2*NUM_PORTS). Outside it, rd_hit is 0 and rd_data is 0, and writes change nothing.
- R2: Ring index = (addr-WIN_BASE)/32 and offset = (addr-WIN_BASE)%32. Offsets are 0x00 base low, 0x04 base high, 0x08 size, 0x0C head, 0x10 tail, 0x14 control, 0x18 credits. Any other offset reads 0, and writes to it are ignored.
- R3: A 32-bit write at 0x00 loads one low-half latch shared by all rings. A 32-bit write at 0x04 of any ring sets that ring's base to {data, latch} and clears the latch. A 64-bit write at 0x00 loads the whole base and leaves the latch alone. 32-bit reads at 0x00 and 0x04 return the low and high halves. A 64-bit read at 0x00 returns the full base.
- R4: A 64-bit access at any offset other than 0x00 reads 0, and a 64-bit write there is ignored.
- R5: A size write stores the value and clears head and tail. Size, head, tail and credits read back zero-extended in 32-bit reads. The control offset reads 0.
- R6: A head write is accepted only when the value is below the size. An accepted value that differs from the current head is stored and requests an interrupt. Any other head write changes nothing.
- R7: A credit write of n sets credits to max(credits-n, 0) and requests an interrupt when that result is nonzero. A same-cycle post to that ring then adds one.
- R8: A control write stores bit 1 as the ring enable. When bit 0 is set, the write also clears head, tail and credits. The clear takes precedence over a post in the same cycle.
- R9: A post to an enabled ring of nonzero size advances the tail by one, wrapping to 0 at the size, and adds one credit. A post to any other ring does nothing. A same-cycle size write clears the tail instead. Tail writes are ignored.
- R10: irq_valid pulses in the cycle after the requesting write. The vector is 0 for ring 0, 1 for ring 1 and i+1 for ring i >= 2, so vector 2 is never used. irq_port is 0 for rings 0 and 1 and (i-2)/2+1 otherwise. irq_rx is 1 for odd i >= 2, so port p receives on ring (p-1)*2+3.
- R11: Reset clears every base, size, head, tail, credit, enable and the latch, and holds irq_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_wide | input | 1 | Write is 64 bits wide |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data (low 32 bits for narrow writes) |
| rd_wide | input | 1 | Read is 64 bits wide |
| rd_addr | input | ADDR_W | Read byte address |
| rd_hit | output | 1 | Read address lies in the ring window |
| rd_data | output | 64 | Read data |
| post_en | input | 1 | Descriptor engine posted one descriptor |
| post_ring | input | clog2(2+2*NUM_PORTS) | Ring of the posted descriptor |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_vector | output | clog2(2*NUM_PORTS+3) | Vector of the requesting ring |
| irq_port | output | clog2(NUM_PORTS+1) | 1-based port of the requesting ring, 0 for command/event |
| irq_rx | output | 1 | Requesting ring is a receive ring |

## Verification
A credit return from the bus and a descriptor post from the engine can land on the same ring in the same cycle. The saturating subtraction must come first and the increment after, and the interrupt decision must use the value from before the increment. The bench drives returns both smaller and larger than the outstanding count together with a post to that ring. It then reads the credits back and checks whether an interrupt pulse follows. The same pairing of a post with a size write or a clearing control write shows whether the write wins over the tail advance.

// File: rtl/ring_reg_decoder.sv
`timescale 1ns/1ps
module ring_reg_decoder #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W = 16,
  parameter int STRIDE_LOG2 = 5,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_wide,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0] wr_data,
  input  logic rd_wide,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic rd_hit,
  output logic [63:0] rd_data,
  input  logic post_en,
  input  logic [$clog2(2+2*NUM_PORTS)-1:0] post_ring,
  output logic irq_valid,
  output logic [$clog2(2*NUM_PORTS+3)-1:0] irq_vector,
  output logic [$clog2(NUM_PORTS+1)-1:0] irq_port,
  output logic irq_rx
);
  localparam int NR = 2 + 2*NUM_PORTS;
  localparam int IDX_W = $clog2(NR);
  localparam int VEC_W = $clog2(NR + 1);
  localparam int PORT_W = $clog2(NUM_PORTS + 1);
  localparam logic [ADDR_W:0] WIN_LEN = (ADDR_W+1)'(NR << STRIDE_LOG2);
  typedef logic [STRIDE_LOG2-1:0] off_t;
  localparam off_t OFF_BLO  = off_t'(0);
  localparam off_t OFF_BHI  = off_t'(4);
  localparam off_t OFF_SIZE = off_t'(8);
  localparam off_t OFF_HEAD = off_t'(12);
  localparam off_t OFF_TAIL = off_t'(16);
  localparam off_t OFF_CTRL = off_t'(20);
  localparam off_t OFF_CRED = off_t'(24);

  logic [ADDR_W-1:0] wr_rel, rd_rel;
  logic wr_in, rd_in, wr_go, wr32;
  logic [IDX_W-1:0] wr_idx, rd_idx, irq_ring;
  off_t wr_off, rd_off;
  logic [31:0] wd, lo_latch;

  assign wr_rel = wr_addr - WIN_BASE;
  assign rd_rel = rd_addr - WIN_BASE;
  assign wr_in  = (wr_addr >= WIN_BASE) && ({1'b0, wr_rel} < WIN_LEN);
  assign rd_in  = (rd_addr >= WIN_BASE) && ({1'b0, rd_rel} < WIN_LEN);
  assign wr_idx = wr_rel[STRIDE_LOG2 +: IDX_W];
  assign rd_idx = rd_rel[STRIDE_LOG2 +: IDX_W];
  assign wr_off = wr_rel[STRIDE_LOG2-1:0];
  assign rd_off = rd_rel[STRIDE_LOG2-1:0];
  assign wr_go  = wr_en && wr_in;
  assign wr32   = wr_go && !wr_wide;
  assign wd     = wr_data[31:0];
  assign rd_hit = rd_in;

  logic [63:0] base_q [NR];
  logic [31:0] size_q [NR];
  logic [31:0] head_q [NR];
  logic [31:0] tail_q [NR];
  logic [31:0] cred_q [NR];
  logic [NR-1:0] en_q;

  logic [NR-1:0] wsel, psel, head_acc, cred_irq;
  logic [31:0] cred_sat [NR];
  logic [31:0] tail_nxt [NR];

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      wsel[i] = wr_go && (wr_idx == IDX_W'(i));
      psel[i] = post_en && (post_ring == IDX_W'(i)) && en_q[i] && (size_q[i] != '0);
      tail_nxt[i] = (tail_q[i] + 32'd1 == size_q[i]) ? '0 : tail_q[i] + 32'd1;
      if (wsel[i] && !wr_wide && wr_off == OFF_CRED)
        cred_sat[i] = (cred_q[i] > wd) ? cred_q[i] - wd : '0;
      else
        cred_sat[i] = cred_q[i];
      cred_irq[i] = wsel[i] && !wr_wide && (wr_off == OFF_CRED) && (cred_sat[i] != '0);
      head_acc[i] = wsel[i] && !wr_wide && (wr_off == OFF_HEAD) &&
                    (wd < size_q[i]) && (wd != head_q[i]);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NR; i++) begin
      if (rd_in && rd_idx == IDX_W'(i)) begin
        if (rd_wide) begin
          if (rd_off == OFF_BLO) rd_data = base_q[i];
        end else begin
          case (rd_off)
            OFF_BLO:  rd_data = {32'd0, base_q[i][31:0]};
            OFF_BHI:  rd_data = {32'd0, base_q[i][63:32]};
            OFF_SIZE: rd_data = {32'd0, size_q[i]};
            OFF_HEAD: rd_data = {32'd0, head_q[i]};
            OFF_TAIL: rd_data = {32'd0, tail_q[i]};
            OFF_CRED: rd_data = {32'd0, cred_q[i]};
            default:  rd_data = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        head_q[i] <= '0;
        tail_q[i] <= '0;
        cred_q[i] <= '0;
      end
      en_q      <= '0;
      lo_latch  <= '0;
      irq_valid <= 1'b0;
      irq_ring  <= '0;
    end else begin
      irq_valid <= (|head_acc) || (|cred_irq);
      if (wr_go) irq_ring <= wr_idx;
      if (wr32 && wr_off == OFF_BLO) lo_latch <= wd;
      else if (wr32 && wr_off == OFF_BHI) lo_latch <= '0;
      for (int i = 0; i < NR; i++) begin
        cred_q[i] <= cred_sat[i] + 32'(psel[i]);
        if (psel[i]) tail_q[i] <= tail_nxt[i];
        if (wsel[i] && wr_wide && wr_off == OFF_BLO) base_q[i] <= wr_data;
        if (wsel[i] && !wr_wide) begin
          case (wr_off)
            OFF_BHI: base_q[i] <= {wd, lo_latch};
            OFF_SIZE: begin
              size_q[i] <= wd;
              head_q[i] <= '0;
              tail_q[i] <= '0;
            end
            OFF_HEAD: if (head_acc[i]) head_q[i] <= wd;
            OFF_CTRL: begin
              en_q[i] <= wd[1];
              if (wd[0]) begin
                head_q[i] <= '0;
                tail_q[i] <= '0;
                cred_q[i] <= '0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign irq_vector = (irq_ring < IDX_W'(2)) ? VEC_W'(irq_ring) : VEC_W'(irq_ring) + VEC_W'(1);
  assign irq_port   = (irq_ring < IDX_W'(2)) ? '0 : PORT_W'(irq_ring >> 1);
  assign irq_rx     = irq_ring[0] && (irq_ring >= IDX_W'(2));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(wr_en && !wr_wide)) else $error("irq without narrow write");
  p_irq_vec_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector != VEC_W'(2)) else $error("reserved vector used");
  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == '0) else $error("data outside window");

  for (genvar g = 0; g < NR; g++) begin : g_ring_chk
    p_head_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (head_q[g] < size_q[g]) || (head_q[g] == '0)) else $error("head past size");
    p_tail_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q[g] < size_q[g]) || (tail_q[g] == '0)) else $error("tail past size");
    p_ctrl_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel[g] && !wr_wide && wr_off == OFF_CTRL && wd[0]) |=>
        (head_q[g] == '0 && tail_q[g] == '0 && cred_q[g] == '0)) else $error("clear missed");
  end
endmodule

// File: tb/ring_reg_decoder_tb.sv
`timescale 1ns/1ps
module ring_reg_decoder_tb;
  localparam int NP = 4;
  localparam int NR = 2 + 2*NP;
  localparam int BASE = 'h1000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_wide = 0, rd_wide = 0, post_en = 0;
  logic [15:0] wr_addr = 0, rd_addr = 0;
  logic [63:0] wr_data = 0;
  logic [3:0] post_ring = 0;
  logic rd_hit, irq_valid, irq_rx;
  logic [63:0] rd_data;
  logic [3:0] irq_vector;
  logic [2:0] irq_port;

  ring_reg_decoder #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_wide(rd_wide), .rd_addr(rd_addr), .rd_hit(rd_hit),
    .rd_data(rd_data), .post_en(post_en), .post_ring(post_ring), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_port(irq_port), .irq_rx(irq_rx));

  always #10 clk = ~clk;

  logic [63:0] m_base [NR];
  int unsigned m_size [NR], m_head [NR], m_tail [NR], m_cred [NR];
  bit m_en [NR];
  logic [31:0] m_lat;
  bit e_irq;
  int e_ring;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic int A(int ring, int off);
    return BASE + ring*32 + off;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(int a);
    return a >= BASE && a < BASE + NR*32;
  endfunction

  function automatic logic [63:0] exp_rd(bit rw, int ra);
    int idx, off;
    if (!in_win(ra)) return 64'd0;
    idx = (ra - BASE) / 32;
    off = (ra - BASE) % 32;
    if (rw) return (off == 0) ? m_base[idx] : 64'd0;
    case (off)
      0:  return {32'd0, m_base[idx][31:0]};
      4:  return {32'd0, m_base[idx][63:32]};
      8:  return {32'd0, m_size[idx]};
      12: return {32'd0, m_head[idx]};
      16: return {32'd0, m_tail[idx]};
      24: return {32'd0, m_cred[idx]};
      default: return 64'd0;
    endcase
  endfunction

  task automatic model_apply(bit we, bit ww, int wa, logic [63:0] wd, bit pe, int pr);
    int idx, off;
    bit hit;
    int unsigned d;
    d = wd[31:0];
    e_irq = 0;
    hit = we && in_win(wa);
    idx = hit ? (wa - BASE) / 32 : 0;
    off = hit ? (wa - BASE) % 32 : 0;
    if (hit && !ww && off == 24) begin
      m_cred[idx] = (m_cred[idx] > d) ? m_cred[idx] - d : 0;
      if (m_cred[idx] != 0) begin e_irq = 1; e_ring = idx; end
    end
    if (pe && m_en[pr] && m_size[pr] != 0) begin
      m_tail[pr] = (m_tail[pr] + 1 == m_size[pr]) ? 0 : m_tail[pr] + 1;
      m_cred[pr] = m_cred[pr] + 1;
    end
    if (hit && ww && off == 0) m_base[idx] = wd;
    if (hit && !ww) begin
      case (off)
        0: m_lat = d;
        4: begin m_base[idx] = {d, m_lat}; m_lat = 0; end
        8: begin m_size[idx] = d; m_head[idx] = 0; m_tail[idx] = 0; end
        12: if (d < m_size[idx] && d != m_head[idx]) begin
              m_head[idx] = d; e_irq = 1; e_ring = idx;
            end
        20: begin
              m_en[idx] = d[1];
              if (d[0]) begin m_head[idx] = 0; m_tail[idx] = 0; m_cred[idx] = 0; end
            end
        default: ;
      endcase
    end
  endtask

  task automatic step(bit we, bit ww, int wa, logic [63:0] wd, bit rw, int ra,
                      bit pe, int pr, string tag);
    wr_en = we; wr_wide = ww; wr_addr = 16'(wa); wr_data = wd;
    rd_wide = rw; rd_addr = 16'(ra); post_en = pe; post_ring = 4'(pr);
    @(posedge clk);
    @(negedge clk);
    model_apply(we, ww, wa, wd, pe, pr);
    check(tag, "rd_hit", {63'd0, rd_hit}, {63'd0, in_win(ra)});
    check(tag, "rd_data", rd_data, exp_rd(rw, ra));
    check(tag, "irq_valid", {63'd0, irq_valid}, {63'd0, e_irq});
    if (e_irq && irq_valid) begin
      check("R10", "irq_vector", 64'(irq_vector), 64'((e_ring < 2) ? e_ring : e_ring + 1));
      check("R10", "irq_port", 64'(irq_port), 64'((e_ring < 2) ? 0 : (e_ring - 2)/2 + 1));
      check("R10", "irq_rx", 64'(irq_rx), 64'(e_ring >= 2 && e_ring % 2 == 1));
    end
  endtask

  function automatic string tag_for(bit rw, int ra);
    int off;
    if (!in_win(ra)) return "R1";
    off = (ra - BASE) % 32;
    if (rw) return (off == 0) ? "R3" : "R4";
    case (off)
      0, 4: return "R3";
      8: return "R5";
      12: return "R6";
      16: return "R9";
      20: return "R8";
      24: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic int rand_addr();
    if ($urandom_range(0, 19) == 0) return BASE - 4*int'($urandom_range(1, 8));
    return A(int'($urandom_range(0, NR)), 4*int'($urandom_range(0, 7)));
  endfunction

  function automatic logic [63:0] rand_data(int wa);
    int off;
    off = in_win(wa) ? (wa - BASE) % 32 : 0;
    case (off)
      8:  return {$urandom, 32'($urandom_range(0, 6))};
      12: return {$urandom, 32'($urandom_range(0, 7))};
      24: return {$urandom, 32'($urandom_range(0, 4))};
      20: return {$urandom, 30'd0, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0)};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_head[i] = 0; m_tail[i] = 0; m_cred[i] = 0; m_en[i] = 0;
    end
    m_lat = 0;
    e_ring = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", "irq_valid in reset", {63'd0, irq_valid}, 64'd0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, A(3, 8), 0, 0, "R11");
    step(0, 0, 0, 0, 1, A(0, 0), 0, 0, "R11");
    step(0, 0, 0, 0, 0, A(9, 24), 0, 0, "R11");
    // shared low latch across rings
    step(1, 0, A(2, 0), 64'hAAAA_BBBB_1234_5678, 0, A(2, 0), 0, 0, "R3");
    step(1, 0, A(5, 4), 64'h0000_0000_9ABC_DEF0, 1, A(5, 0), 0, 0, "R3");
    step(1, 0, A(5, 4), 64'h0000_0000_0000_1111, 1, A(5, 0), 0, 0, "R3");
    step(1, 1, A(6, 0), 64'hFEDC_BA98_7654_3210, 1, A(6, 0), 0, 0, "R3");
    step(0, 0, 0, 0, 0, A(6, 4), 0, 0, "R3");
    step(1, 1, A(6, 8), 64'h5, 1, A(6, 8), 0, 0, "R4");
    step(0, 0, 0, 0, 0, A(6, 8), 0, 0, "R4");
    step(1, 0, A(3, 8), 64'd4, 0, A(3, 8), 0, 0, "R5");
    step(1, 0, A(3, 20), 64'd2, 0, A(3, 20), 0, 0, "R8");
    step(1, 0, A(3, 12), 64'd5, 0, A(3, 12), 0, 0, "R6");
    step(1, 0, A(3, 12), 64'd3, 0, A(3, 12), 0, 0, "R6");
    step(1, 0, A(3, 12), 64'd3, 0, A(3, 12), 0, 0, "R6");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, A(3, 16), 1, 3, "R9");
    step(1, 0, A(3, 16), 64'd2, 0, A(3, 16), 0, 0, "R9");
    step(0, 0, 0, 0, 0, A(4, 16), 1, 4, "R9");
    step(1, 0, A(3, 24), 64'd2, 0, A(3, 24), 0, 0, "R7");
    step(1, 0, A(3, 24), 64'd1, 0, A(3, 24), 1, 3, "R7");
    step(1, 0, A(3, 24), 64'd9, 0, A(3, 24), 1, 3, "R7");
    step(1, 0, A(3, 24), 64'd7, 0, A(3, 24), 0, 0, "R7");
    step(1, 0, A(3, 20), 64'd3, 0, A(3, 12), 1, 3, "R8");
    step(0, 0, 0, 0, 0, A(3, 16), 0, 0, "R8");
    step(1, 0, A(3, 28), 64'd9, 0, A(3, 28), 0, 0, "R2");
    step(1, 0, A(NR, 8), 64'd7, 0, A(NR, 8), 0, 0, "R1");
    step(1, 0, BASE - 24, 64'd7, 0, BASE - 24, 0, 0, "R1");
    step(1, 0, A(8, 8), 64'd3, 0, A(8, 8), 0, 0, "R5");
    step(1, 0, A(8, 12), 64'd1, 0, A(8, 12), 0, 0, "R10");
    step(1, 0, A(0, 8), 64'd2, 0, A(0, 8), 0, 0, "R5");
    step(1, 0, A(0, 12), 64'd1, 0, A(0, 12), 0, 0, "R10");
    step(1, 0, A(1, 8), 64'd4, 0, A(1, 8), 0, 0, "R5");
    step(1, 0, A(1, 20), 64'd2, 0, A(1, 16), 0, 0, "R8");
    step(0, 0, 0, 0, 0, A(1, 24), 1, 1, "R9");
    step(1, 0, A(1, 24), 64'd0, 0, A(1, 24), 0, 0, "R10");
    for (int k = 0; k < 4000; k++) begin
      int wa, ra;
      bit rw;
      wa = rand_addr();
      ra = rand_addr();
      rw = ($urandom_range(0, 5) == 0);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0, wa, rand_data(wa),
           rw, ra, $urandom_range(0, 1) == 1, int'($urandom_range(0, NR - 1)), tag_for(rw, ra));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule